// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block connects one on-chip master to an external asynchronous static RAM. The RAM holds 32768 bytes. The master hands over one word request at a time through a ready/valid handshake. A request carries an address, write data and a direction flag. The controller then runs the active-low chip-select, write-strobe and read-strobe lines and the 15-bit address bus, and it drives or samples the 8-bit data bus. Read data comes back with a one-cycle valid pulse.

Each access is built from separate phases, and each phase lasts a whole number of clock cycles: address setup, write pulse, data setup, read access, bus turnaround and recovery. The cycle counts are derived at elaboration. Each one is the nanosecond figure of the chosen speed grade divided by the clock period and rounded up. The defaults match the slowest grade at a 125 MHz clock.

The data bus is split into an output, an output enable and an input, so that the pad ring can build the bidirectional pins. The controller changes the address only while the chip-select and write-strobe lines are both inactive. It drives the data bus only inside a write pulse, while the read strobe is inactive. After a read it waits a turnaround before it drives again, so that the memory has released the bus.

Top module: `asram_bridge`

## Requirements
- R1: During reset and afterwards while idle, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rsp_valid is 0. Once reset is released, req_ready is 1.
- R2: A request is accepted on a rising clock edge where req_valid and req_ready are both 1. req_ready is 0 in the cycle that follows acceptance and stays 0 until the access and its cycle time are finished. Requests are carried out, and read data returned, in the order they were accepted.
- R3: mem_addr changes only on an edge after a cycle in which mem_ce_n and mem_we_n were both 1. It holds steady while mem_ce_n stays 0.
- R4: A write holds mem_ce_n and mem_we_n at 0 together for exactly WP cycles. mem_oe_n stays 1 for the whole write. WP is the cycle count for the write pulse width, raised to at least the data setup count.
- R5: During a write, mem_dq_oe is 1 for exactly the last DS cycles of the pulse, with mem_dq_out equal to the request's write data. It falls on the same edge on which mem_we_n rises. mem_dq_oe is never 1 unless mem_ce_n=0, mem_we_n=0 and mem_oe_n=1. DS is the data setup count.
- R6: A read holds mem_ce_n and mem_oe_n at 0, with mem_we_n at 1, for exactly RD cycles. The controller samples mem_dq_in on the edge that ends the last of these cycles. rsp_valid is 1 for one cycle, the first cycle in which the strobes are high again, and rsp_rdata then holds the sampled byte.
- R7: Two successive falls of mem_ce_n are at least CYC cycles apart. CYC is the cycle-time count. Writes issued back to back with req_valid held high start exactly CYC cycles apart when the address setup count is 0.
- R8: After a read, mem_dq_oe first rises only after at least TURN+1 cycles with mem_oe_n at 1. TURN is the turnaround count and is at least 1.
- R9: Each count is the smallest whole number of 8 ns clock cycles that covers its nanosecond figure. With the defaults, the read strobe lasts 9 cycles (72 ns against 70 ns) and the write pulse lasts 7 cycles (56 ns against 55 ns).
- R10: Whenever req_ready is 1, mem_ce_n is 1, so the memory stays in standby.
- R11: mem_oe_n and mem_we_n are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_dq_out | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Data bus value seen at the pins |

## Verification
The bench's memory model places the stored byte on the bus only in the last cycle of the read strobe and shows filler at all other times. A controller that samples one edge early or one edge late therefore returns the filler instead of the stored byte. Back-to-back writes with the request held high pin the cycle-time spacing to the exact cycle, so an off-by-one in the recovery count shows up as a wrong gap. A write that directly follows a read tests the turnaround: a controller that skipped it would turn on its data driver while the memory might still be driving. The model also records every address change made while a strobe was active and every cycle in which the write and read strobes overlapped, and the bench checks that none occurred.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_WRITE,
        ST_READ,
        ST_RECOVER
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   is_wr;
        logic   last_rd;
        logic   ce_n;
        logic   we_n;
        logic   oe_n;
    } ctl_s;

    // Ceiling of a nanosecond figure over the clock period, with a lower bound.
    function automatic int ns_to_cycles(input int ns, input int period_ps, input int low);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < low) ? low : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expiring
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count    = cnt_q;
    assign expiring = (cnt_q <= W'(1));

    // Counter saturates at zero and never wraps (cycle-time window, R7)
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW = 15,
    parameter int DW = 8,
    parameter int CW = 4,
    parameter int DS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic          wr_phase,
    input  logic [CW-1:0] ph_cnt,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    logic [AW-1:0] addr_d, addr_q;
    logic [DW-1:0] wdat_d, wdat_q;
    logic [DW-1:0] rdat_d, rdat_q;
    logic          rvld_d, rvld_q;

    always_comb begin
        addr_d = addr_q;
        wdat_d = wdat_q;
        rdat_d = rdat_q;
        rvld_d = capture;
        if (accept) begin
            addr_d = req_addr;
            wdat_d = req_wdata;
        end
        if (capture) begin
            rdat_d = mem_dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            rvld_q <= 1'b0;
        end else begin
            addr_q <= addr_d;
            wdat_q <= wdat_d;
            rdat_q <= rdat_d;
            rvld_q <= rvld_d;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdat_q;
    // Drive only in the tail of the write pulse that covers the data setup window
    assign mem_dq_oe  = wr_phase && (ph_cnt <= CW'(DS));
    assign rsp_valid  = rvld_q;
    assign rsp_rdata  = rdat_q;

    // Read response is a single-cycle pulse (R6)
    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int CLK_PS      = 8000,
    parameter int T_CYCLE_NS  = 70,
    parameter int T_WPULSE_NS = 55,
    parameter int T_DSETUP_NS = 30,
    parameter int T_ACCESS_NS = 70,
    parameter int T_TURN_NS   = 25,
    parameter int T_ASETUP_NS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int DS_CYC   = ns_to_cycles(T_DSETUP_NS, CLK_PS, 1);
    localparam int WP_CYC   = imax(ns_to_cycles(T_WPULSE_NS, CLK_PS, 1), DS_CYC);
    localparam int RD_CYC   = ns_to_cycles(T_ACCESS_NS, CLK_PS, 1);
    localparam int CYC_CYC  = ns_to_cycles(T_CYCLE_NS, CLK_PS, 1);
    localparam int TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_PS, 1);
    localparam int AS_CYC   = ns_to_cycles(T_ASETUP_NS, CLK_PS, 0);
    localparam int CNT_MAX  = imax(imax(WP_CYC, RD_CYC), imax(imax(CYC_CYC, TURN_CYC), AS_CYC));
    localparam int CW       = $clog2(CNT_MAX + 1);

    ctl_s          ctl_d, ctl_q;
    logic          ph_load, cyc_load, accept, capture;
    logic [CW-1:0] ph_val, ph_cnt, cyc_cnt;
    logic          ph_last, cyc_last;
    logic          go_op, go_wr;

    asram_timer #(.W(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .count    (ph_cnt),
        .expiring (ph_last)
    );

    asram_timer #(.W(CW)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cyc_load),
        .load_val (CW'(CYC_CYC - 1)),
        .count    (cyc_cnt),
        .expiring (cyc_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        cyc_load = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;
        go_op    = 1'b0;
        go_wr    = ctl_q.is_wr;
        case (ctl_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    accept      = 1'b1;
                    ctl_d.is_wr = req_write;
                    go_wr       = req_write;
                    if (req_write && ctl_q.last_rd) begin
                        ctl_d.phase = ST_TURN;
                        ph_load     = 1'b1;
                        ph_val      = CW'(TURN_CYC);
                    end else if (AS_CYC > 0) begin
                        ctl_d.phase = ST_SETUP;
                        ph_load     = 1'b1;
                        ph_val      = CW'(AS_CYC);
                    end else begin
                        go_op = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (ph_last) begin
                    if (AS_CYC > 0) begin
                        ctl_d.phase = ST_SETUP;
                        ph_load     = 1'b1;
                        ph_val      = CW'(AS_CYC);
                    end else begin
                        go_op = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (ph_last) begin
                    go_op = 1'b1;
                end
            end
            ST_WRITE: begin
                if (ph_last) begin
                    ctl_d.last_rd = 1'b0;
                    ctl_d.phase   = cyc_last ? ST_IDLE : ST_RECOVER;
                end
            end
            ST_READ: begin
                if (ph_last) begin
                    capture       = 1'b1;
                    ctl_d.last_rd = 1'b1;
                    ctl_d.phase   = cyc_last ? ST_IDLE : ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (cyc_last) begin
                    ctl_d.phase = ST_IDLE;
                end
            end
            default: ctl_d.phase = ST_IDLE;
        endcase

        if (go_op) begin
            ctl_d.phase = go_wr ? ST_WRITE : ST_READ;
            ph_load     = 1'b1;
            ph_val      = go_wr ? CW'(WP_CYC) : CW'(RD_CYC);
            cyc_load    = 1'b1;
        end

        ctl_d.ce_n = !((ctl_d.phase == ST_WRITE) || (ctl_d.phase == ST_READ));
        ctl_d.we_n = !(ctl_d.phase == ST_WRITE);
        ctl_d.oe_n = !(ctl_d.phase == ST_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: ST_IDLE, is_wr: 1'b0, last_rd: 1'b0,
                       ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.phase == ST_IDLE);
    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;

    asram_datapath #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .CW (CW),
        .DS (DS_CYC)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .wr_phase   (ctl_q.phase == ST_WRITE),
        .ph_cnt     (ph_cnt),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    // Cycles with the read strobe high since it was last low, for the turnaround check
    logic [7:0] since_oe_d, since_oe_q;
    always_comb begin
        since_oe_d = since_oe_q;
        if (!mem_oe_n) begin
            since_oe_d = '0;
        end else if (since_oe_q != 8'hFF) begin
            since_oe_d = since_oe_q + 8'd1;
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_oe_q <= 8'hFF;
        end else begin
            since_oe_q <= since_oe_d;
        end
    end

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_addr_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |-> ($past(mem_ce_n) && $past(mem_we_n)));

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(since_oe_q) >= imax(TURN_CYC + 1, 1) || since_oe_q == 8'hFF));

    assert_idle_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

endmodule

// File: tb/asram_bridge_test.sv
`timescale 1ns/1ps
module asram_bridge_test;

    localparam int P_PS = 8000;

    function automatic int to_cyc(input int ns);
        int c;
        c = (ns * 1000 + P_PS - 1) / P_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int EXP_DS   = to_cyc(30);
    localparam int EXP_WP   = (to_cyc(55) > EXP_DS) ? to_cyc(55) : EXP_DS;
    localparam int EXP_RD   = to_cyc(70);
    localparam int EXP_CYC  = to_cyc(70);
    localparam int EXP_TURN = to_cyc(25);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = 8'h5A;

    always #4 clk = ~clk;

    asram_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Memory model and bus monitor, sampled on the falling edge
    logic [7:0]  model [int];
    logic [7:0]  rsp_q [$];
    int          cyc_n = 0;
    logic        prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
    logic [14:0] prev_addr = '0;
    int          last_start = -1000, last_gap = 0;
    int          wlen = 0, wdrive = 0, rec_wlen = 0, rec_wdrive = 0;
    logic        rec_tail = 1'b0;
    logic [7:0]  wlast = '0;
    int          rdlen = 0, rec_rdlen = 0, rd_end_cyc = -1, rsp_cyc = -2;
    int          oe_high_run = 1000, rec_turn = 0;
    int          viol_addr = 0, viol_excl = 0, viol_drive = 0, viol_standby = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc_n <= cyc_n + 1;
            if ((mem_addr != prev_addr) && (!prev_ce || !prev_we)) viol_addr++;
            if (!mem_oe_n && !mem_we_n) viol_excl++;
            if (mem_dq_oe && (mem_we_n || mem_ce_n || !mem_oe_n)) viol_drive++;
            if (req_ready && !mem_ce_n) viol_standby++;
            if (!mem_ce_n && prev_ce) begin
                last_gap   = cyc_n - last_start;
                last_start = cyc_n;
            end
            if (!mem_we_n) begin
                wlen++;
                if (mem_dq_oe) begin
                    wdrive++;
                    wlast = mem_dq_out;
                end
            end else if (!prev_we) begin
                rec_wlen   = wlen;
                rec_wdrive = wdrive;
                rec_tail   = prev_dqoe;
                model[int'(prev_addr)] = wlast;
                wlen = 0;
                wdrive = 0;
            end
            if (mem_dq_oe && !prev_dqoe) rec_turn = oe_high_run;
            if (!mem_oe_n) oe_high_run = 0;
            else oe_high_run++;
            if (!mem_ce_n && !mem_oe_n) begin
                rdlen++;
                if (rdlen >= EXP_RD && model.exists(int'(mem_addr)))
                    mem_dq_in <= model[int'(mem_addr)];
                else
                    mem_dq_in <= 8'h5A;
            end else begin
                if (rdlen != 0) begin
                    rec_rdlen  = rdlen;
                    rd_end_cyc = cyc_n;
                end
                rdlen = 0;
                mem_dq_in <= 8'h5A;
            end
            if (rsp_valid) begin
                rsp_cyc = cyc_n;
                rsp_q.push_back(rsp_rdata);
            end
            prev_ce   = mem_ce_n;
            prev_we   = mem_we_n;
            prev_oe   = mem_oe_n;
            prev_dqoe = mem_dq_oe;
            prev_addr = mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d);
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_wait(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic int stored(input logic [14:0] a);
        return model.exists(int'(a)) ? int'(model[int'(a)]) : -1;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        check(!mem_dq_oe && !rsp_valid, "R1 drive/rsp in reset", {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(mem_ce_n == 1'b1, "R1 standby after reset", mem_ce_n, 1);
    endtask

    task automatic t_write_read(input logic [14:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        idle_wait(12);
        check(rec_wlen == EXP_WP, "R4 write pulse length", rec_wlen, EXP_WP);
        check(rec_wdrive == EXP_DS, "R5 drive cycles", rec_wdrive, EXP_DS);
        check(rec_tail == 1'b1, "R5 drive until strobe rise", rec_tail, 1);
        check(stored(a) == int'(d), "R5 data written", stored(a), d);
        rsp_q.delete();
        issue(1'b0, a, 8'h00);
        idle_wait(13);
        check(rsp_q.size() == 1, "R6 one response", rsp_q.size(), 1);
        if (rsp_q.size() > 0)
            check(rsp_q[0] == d, "R6 read data", rsp_q[0], d);
        check(rec_rdlen == EXP_RD, "R6 read strobe length", rec_rdlen, EXP_RD);
        check(rsp_cyc == rd_end_cyc, "R6 response cycle", rsp_cyc, rd_end_cyc);
        rsp_q.delete();
    endtask

    task automatic t_ceiling();
        check((rec_rdlen * 8 >= 70) && ((rec_rdlen - 1) * 8 < 70), "R9 read cycles cover 70ns",
              rec_rdlen, 9);
        check((rec_wlen * 8 >= 55) && ((rec_wlen - 1) * 8 < 55), "R9 write cycles cover 55ns",
              rec_wlen, 7);
    endtask

    task automatic t_b2b_writes();
        issue(1'b1, 15'h0100, 8'h11);
        issue(1'b1, 15'h0101, 8'h22);
        idle_wait(12);
        check(last_gap == EXP_CYC, "R7 write to write spacing", last_gap, EXP_CYC);
        check(stored(15'h0101) == 8'h22, "R5 second write data", stored(15'h0101), 8'h22);
    endtask

    task automatic t_b2b_reads();
        rsp_q.delete();
        issue(1'b0, 15'h0100, 8'h00);
        issue(1'b0, 15'h0101, 8'h00);
        idle_wait(14);
        check(last_gap >= EXP_CYC, "R7 read to read spacing", last_gap, EXP_CYC);
        check(rsp_q.size() == 2, "R2 response count", rsp_q.size(), 2);
        if (rsp_q.size() == 2) begin
            check(rsp_q[0] == 8'h11, "R2 first response in order", rsp_q[0], 8'h11);
            check(rsp_q[1] == 8'h22, "R2 second response in order", rsp_q[1], 8'h22);
        end
        rsp_q.delete();
    endtask

    task automatic t_turn();
        issue(1'b0, 15'h0100, 8'h00);
        issue(1'b1, 15'h0200, 8'h3C);
        idle_wait(20);
        check(rec_turn >= EXP_TURN + 1, "R8 turnaround before drive", rec_turn, EXP_TURN + 1);
        check(stored(15'h0200) == 8'h3C, "R8 write after read data", stored(15'h0200), 8'h3C);
        rsp_q.delete();
    endtask

    initial begin
        t_reset();
        t_write_read(15'h0000, 8'h00);
        t_write_read(15'h7FFF, 8'hFF);
        t_write_read(15'h1234, 8'hA5);
        t_ceiling();
        t_b2b_writes();
        t_b2b_reads();
        t_turn();
        check(viol_addr == 0, "R3 address moved under strobe", viol_addr, 0);
        check(viol_drive == 0, "R5 drive outside write window", viol_drive, 0);
        check(viol_standby == 0, "R10 chip select while idle", viol_standby, 0);
        check(viol_excl == 0, "R11 read and write strobes overlap", viol_excl, 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

endmodule